// File: doc/BRIEF.md
# Multi-Channel Event Timer

A register-mapped event timer. One 64-bit up-counter advances by one per clock while a global enable is set, and it freezes when the enable is clear. Several comparator channels share this counter. A channel signals an event on any enabled clock cycle in which its match value equals the counter. The event sets a status bit and drives that channel's interrupt output. The output is either a level held until software acknowledges it, or a one-cycle pulse.

Software reaches the block over a single-cycle 32-bit register port. The port has byte write strobes and a combinational read path. The period of one counter tick, in femtoseconds, is a build parameter and can be read from a fixed word. Each channel can work in one of two ways:
- one-shot, where the match value stays where software put it;
- periodic, where every match moves the match value forward by a stored period.

A channel can also compare only the low 32 bits. A 5-bit routing field and a message-delivery enable are stored for each channel and read back, but they do not change the interrupt outputs.

Top module: `evt_timer`

## Requirements
- R1: After reset every register, the counter and all interrupt outputs are zero. The word at offset 0x04 reads the tick-period parameter. Reads return zero for offset 0x00, for any offset that is not word-aligned, for any unmapped offset, and for channel slots at or above the channel count.
- R2: While bit 0 of the global configuration register (offset 0x10) is 1, the counter increments once per clock, with carry from the low half into the high half. While that bit is 0, the counter holds its value. The counter halves are at 0xF0 (low) and 0xF4 (high), and both can be written.
- R3: Bit 1 of the global configuration register is stored and read back. It does not start the counter.
- R4: Channel n has its configuration word at 0x100+0x20*n, its comparator low word at +0x08 and its comparator high word at +0x0C. With the counter running, a 64-bit equality between counter and comparator sets bit n of the status register (offset 0x20) on the next clock edge.
- R5: In level mode (configuration bit 1 = 1), the interrupt output stays high while the status bit and the enable (bit 2) are both set. Writing 1 to that status bit clears it and drops the output.
- R6: In edge mode (bit 1 = 0), an enabled channel pulses its interrupt output high for exactly one cycle per match. Writing 1 to its status bit has no effect, and the bit stays set.
- R7: A match sets the status bit even when the interrupt enable is 0. With the enable at 0 the output stays low, and it rises once the enable is set in level mode.
- R8: In periodic mode (bit 3), a comparator write made while the value-set bit (bit 6) is 1 loads both the match value and the period. Bit 6 clears after the high-word write, or after the low-word write in 32-bit mode. Each match adds the period to the match value.
- R9: In 32-bit mode (bit 8), only the low 32 bits of counter and comparator are compared. The comparator high word reads zero, and writes to it are ignored.
- R10: Bits 13:9 (routing) and bit 14 (message enable) are stored and read back. Bits 0, 5:4, 7 and 31:15 read zero. None of these bits affects the interrupt outputs.
- R11: A write changes only the bytes whose strobe is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W | Byte address of the access |
| busWe | input | 1 | Write enable for the current cycle |
| busStrb | input | 4 | Byte write strobes |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| irqOut | output | NCH | One interrupt output per channel |

## Verification
The matching logic is tried with several counter and comparator patterns:
- A counter frozen just below the match value and then released, to separate a true match from a frozen counter.
- A counter crossing a 32-bit boundary against three channels: 64-bit compare with the right high word, 64-bit compare with the wrong high word, and 32-bit compare. This separates full-width from low-half matching.
- A periodic channel observed after its first and its second match, which shows whether the period is added or the match value is simply left in place.
- Level, edge and disabled-enable configurations for the same match, which separate status setting from output gating and from acknowledge behaviour.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

  localparam int CH_IDX_W = 3;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_CAP, SEL_GCONF, SEL_STAT, SEL_CNTLO, SEL_CNTHI,
    SEL_CONF, SEL_CMPLO, SEL_CMPHI
  } rdSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrGconf;
    logic wrStat;
    logic wrCntLo;
    logic wrCntHi;
    logic wrConf;
    logic wrCmpLo;
    logic wrCmpHi;
    rdSel_e rdSel;
    logic [CH_IDX_W-1:0] chIdx;
  } strobe_t;

  typedef struct packed {
    logic       msgEn;
    logic [4:0] route;
    logic       wide32;
    logic       valSet;
    logic       periodic;
    logic       intEn;
    logic       levelMode;
  } chCfg_t;

  function automatic logic [31:0] byteMask(input logic [3:0] strb);
    return {{8{strb[3]}}, {8{strb[2]}}, {8{strb[1]}}, {8{strb[0]}}};
  endfunction

  function automatic logic [31:0] mergeBytes(input logic [31:0] old,
                                             input logic [31:0] wdata,
                                             input logic [3:0] strb);
    logic [31:0] m;
    m = byteMask(strb);
    return (old & ~m) | (wdata & m);
  endfunction

  function automatic logic [31:0] cfgWord(input chCfg_t c);
    return {17'b0, c.msgEn, c.route, c.wide32, 1'b0, c.valSet, 2'b0,
            c.periodic, c.intEn, c.levelMode, 1'b0};
  endfunction

  function automatic chCfg_t cfgDecode(input logic [31:0] w);
    chCfg_t c;
    c.msgEn     = w[14];
    c.route     = w[13:9];
    c.wide32    = w[8];
    c.valSet    = w[6];
    c.periodic  = w[3];
    c.intEn     = w[2];
    c.levelMode = w[1];
    return c;
  endfunction

endpackage

// File: rtl/evt_timer_ctrl.sv
module evt_timer_ctrl
  import evt_timer_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int NCH    = 3
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output strobe_t           strobes
);

  logic   chanRange;
  logic   chanValid;
  rdSel_e sel;

  assign chanRange = busAddr[ADDR_W-1:8] == (ADDR_W-8)'(1);
  assign chanValid = chanRange && (int'(busAddr[7:5]) < NCH);

  always_comb begin
    sel = SEL_NONE;
    if (busAddr == ADDR_W'('h004))      sel = SEL_CAP;
    else if (busAddr == ADDR_W'('h010)) sel = SEL_GCONF;
    else if (busAddr == ADDR_W'('h020)) sel = SEL_STAT;
    else if (busAddr == ADDR_W'('h0F0)) sel = SEL_CNTLO;
    else if (busAddr == ADDR_W'('h0F4)) sel = SEL_CNTHI;
    else if (chanValid) begin
      case (busAddr[4:0])
        5'h00:   sel = SEL_CONF;
        5'h08:   sel = SEL_CMPLO;
        5'h0C:   sel = SEL_CMPHI;
        default: sel = SEL_NONE;
      endcase
    end
  end

  always_comb begin
    strobes.rdSel   = sel;
    strobes.chIdx   = busAddr[7:5];
    strobes.wrGconf = busWe && (sel == SEL_GCONF);
    strobes.wrStat  = busWe && (sel == SEL_STAT);
    strobes.wrCntLo = busWe && (sel == SEL_CNTLO);
    strobes.wrCntHi = busWe && (sel == SEL_CNTHI);
    strobes.wrConf  = busWe && (sel == SEL_CONF);
    strobes.wrCmpLo = busWe && (sel == SEL_CMPLO);
    strobes.wrCmpHi = busWe && (sel == SEL_CMPHI);
  end

endmodule

// File: rtl/evt_timer_dp.sv
module evt_timer_dp
  import evt_timer_pkg::*;
#(
  parameter int          NCH       = 3,
  parameter logic [31:0] PERIOD_FS = 32'd10_000_000
) (
  input  logic           clk,
  input  logic           rstN,
  input  strobe_t        strobes,
  input  logic [3:0]     busStrb,
  input  logic [31:0]    busWdata,
  output logic [31:0]    busRdata,
  output logic [NCH-1:0] irqOut,
  output logic [63:0]    cntVal,
  output logic           gEnable,
  output logic [NCH-1:0] hitVec,
  output logic [NCH-1:0] statusVal
);

  logic           legacyQ;
  logic [NCH-1:0] lvlVec;
  logic [NCH-1:0] clrVec;
  logic [31:0]    wMasked;
  chCfg_t         cfgArr   [NCH];
  logic [63:0]    matchArr [NCH];

  // Global configuration and counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gEnable <= 1'b0;
      legacyQ <= 1'b0;
      cntVal  <= '0;
    end else begin
      if (strobes.wrGconf) begin
        gEnable <= busStrb[0] ? busWdata[0] : gEnable;
        legacyQ <= busStrb[0] ? busWdata[1] : legacyQ;
      end
      if (strobes.wrCntLo)
        cntVal <= {cntVal[63:32], mergeBytes(cntVal[31:0], busWdata, busStrb)};
      else if (strobes.wrCntHi)
        cntVal <= {mergeBytes(cntVal[63:32], busWdata, busStrb), cntVal[31:0]};
      else if (gEnable)
        cntVal <= cntVal + 64'd1;
    end
  end

  // Status: match sets, write-one clears level-mode channels only
  assign wMasked = busWdata & byteMask(busStrb);
  assign clrVec  = strobes.wrStat ? (wMasked[NCH-1:0] & lvlVec) : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusVal <= '0;
    else       statusVal <= (statusVal & ~clrVec) | hitVec;
  end

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    chCfg_t      cfgQ;
    logic [63:0] matchQ;
    logic [63:0] periodQ;
    logic        pulseQ;
    logic        selMe;
    logic [31:0] loNew;
    logic [31:0] hiNew;

    assign selMe = strobes.chIdx == CH_IDX_W'(n);
    assign loNew = mergeBytes(matchQ[31:0], busWdata, busStrb);
    assign hiNew = mergeBytes(matchQ[63:32], busWdata, busStrb);
    assign hitVec[n] = gEnable && (cfgQ.wide32 ? (cntVal[31:0] == matchQ[31:0])
                                               : (cntVal == matchQ));
    assign lvlVec[n]   = cfgQ.levelMode;
    assign irqOut[n]   = cfgQ.intEn && (cfgQ.levelMode ? statusVal[n] : pulseQ);
    assign cfgArr[n]   = cfgQ;
    assign matchArr[n] = matchQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cfgQ    <= '0;
        matchQ  <= '0;
        periodQ <= '0;
        pulseQ  <= 1'b0;
      end else begin
        pulseQ <= hitVec[n];
        if (strobes.wrConf && selMe)
          cfgQ <= cfgDecode(mergeBytes(cfgWord(cfgQ), busWdata, busStrb));
        if (strobes.wrCmpLo && selMe) begin
          matchQ[31:0] <= loNew;
          if (cfgQ.periodic && cfgQ.valSet) periodQ[31:0] <= loNew;
          if (cfgQ.wide32) cfgQ.valSet <= 1'b0;
        end else if (strobes.wrCmpHi && selMe) begin
          if (!cfgQ.wide32) begin
            matchQ[63:32] <= hiNew;
            if (cfgQ.periodic && cfgQ.valSet) periodQ[63:32] <= hiNew;
            cfgQ.valSet <= 1'b0;
          end
        end else if (hitVec[n] && cfgQ.periodic) begin
          matchQ <= matchQ + periodQ;
        end
      end
    end
  end

  // Read mux
  chCfg_t      selCfg;
  logic [63:0] selMatch;

  always_comb begin
    selCfg   = '0;
    selMatch = '0;
    for (int i = 0; i < NCH; i++) begin
      if (strobes.chIdx == CH_IDX_W'(i)) begin
        selCfg   = cfgArr[i];
        selMatch = matchArr[i];
      end
    end
  end

  always_comb begin
    case (strobes.rdSel)
      SEL_CAP:   busRdata = PERIOD_FS;
      SEL_GCONF: busRdata = {30'b0, legacyQ, gEnable};
      SEL_STAT:  busRdata = 32'(statusVal);
      SEL_CNTLO: busRdata = cntVal[31:0];
      SEL_CNTHI: busRdata = cntVal[63:32];
      SEL_CONF:  busRdata = cfgWord(selCfg);
      SEL_CMPLO: busRdata = selMatch[31:0];
      SEL_CMPHI: busRdata = selCfg.wide32 ? 32'b0 : selMatch[63:32];
      default:   busRdata = 32'b0;
    endcase
  end

endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter int          NCH       = 3,
  parameter int          ADDR_W    = 12,
  parameter logic [31:0] PERIOD_FS = 32'd10_000_000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [3:0]        busStrb,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic [NCH-1:0]    irqOut
);

  strobe_t        strobes;
  logic [63:0]    cntVal;
  logic           gEnable;
  logic [NCH-1:0] hitVec;
  logic [NCH-1:0] statusVal;

  evt_timer_ctrl #(.ADDR_W(ADDR_W), .NCH(NCH)) ctrl_i (
    .busAddr (busAddr),
    .busWe   (busWe),
    .strobes (strobes)
  );

  evt_timer_dp #(.NCH(NCH), .PERIOD_FS(PERIOD_FS)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .busStrb   (busStrb),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .irqOut    (irqOut),
    .cntVal    (cntVal),
    .gEnable   (gEnable),
    .hitVec    (hitVec),
    .statusVal (statusVal)
  );

endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk
  import evt_timer_pkg::*;
#(
  parameter int NCH = 3
) (
  input logic           clk,
  input logic           rstN,
  input strobe_t        strobes,
  input logic [63:0]    cntVal,
  input logic           gEnable,
  input logic [NCH-1:0] hitVec,
  input logic [NCH-1:0] statusVal,
  input logic [NCH-1:0] irqOut,
  input logic [31:0]    busRdata
);

  logic cntWrite;
  assign cntWrite = strobes.wrCntLo || strobes.wrCntHi;

  a_r2_count_step: assert property (@(posedge clk) disable iff (!rstN)
    (gEnable && !cntWrite) |=> (cntVal == $past(cntVal) + 64'd1));

  a_r2_count_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!gEnable && !cntWrite) |=> $stable(cntVal));

  a_r1_unmapped_zero: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rdSel == SEL_NONE) |-> (busRdata == 32'b0));

  for (genvar n = 0; n < NCH; n++) begin : g_chk
    a_r4_hit_sets_status: assert property (@(posedge clk) disable iff (!rstN)
      hitVec[n] |=> statusVal[n]);

    a_r5_irq_needs_status: assert property (@(posedge clk) disable iff (!rstN)
      irqOut[n] |-> statusVal[n]);
  end

endmodule

bind evt_timer evt_timer_chk #(.NCH(NCH)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .strobes   (strobes),
  .cntVal    (cntVal),
  .gEnable   (gEnable),
  .hitVec    (hitVec),
  .statusVal (statusVal),
  .irqOut    (irqOut),
  .busRdata  (busRdata)
);

// File: tb/evt_timer_tb_top.sv
`timescale 1ns/1ps
module evt_timer_tb_top;

  localparam int NCH = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic        busWe = 1'b0;
  logic [3:0]  busStrb = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [NCH-1:0] irqOut;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  evt_timer #(.NCH(NCH)) dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busStrb(busStrb), .busWdata(busWdata), .busRdata(busRdata),
    .irqOut(irqOut)
  );

  // {wr, addr, strb, data, expected, req}
  localparam int NV = 20;
  localparam logic [84:0] VEC [NV] = '{
    {1'b0, 12'h004, 4'hF, 32'h0, 32'h0098_9680, 4'd1},   // R1 period word
    {1'b0, 12'h000, 4'hF, 32'h0, 32'h0,         4'd1},   // R1
    {1'b0, 12'h010, 4'hF, 32'h0, 32'h0,         4'd1},   // R1
    {1'b0, 12'h020, 4'hF, 32'h0, 32'h0,         4'd1},   // R1
    {1'b0, 12'h0F4, 4'hF, 32'h0, 32'h0,         4'd1},   // R1
    {1'b0, 12'h100, 4'hF, 32'h0, 32'h0,         4'd1},   // R1
    {1'b1, 12'h010, 4'hF, 32'h2, 32'h0,         4'd3},
    {1'b0, 12'h010, 4'hF, 32'h0, 32'h2,         4'd3},   // R3
    {1'b1, 12'h100, 4'hF, 32'h7E01, 32'h0,      4'd10},
    {1'b0, 12'h100, 4'hF, 32'h0, 32'h7E00,      4'd10},  // R10
    {1'b1, 12'h128, 4'h3, 32'hAABB_CCDD, 32'h0, 4'd11},
    {1'b0, 12'h128, 4'hF, 32'h0, 32'h0000_CCDD, 4'd11},  // R11
    {1'b1, 12'h12C, 4'hC, 32'h1122_3344, 32'h0, 4'd11},
    {1'b0, 12'h12C, 4'hF, 32'h0, 32'h1122_0000, 4'd11},  // R11
    {1'b1, 12'h120, 4'hF, 32'h100, 32'h0,       4'd9},
    {1'b0, 12'h12C, 4'hF, 32'h0, 32'h0,         4'd9},   // R9
    {1'b0, 12'h180, 4'hF, 32'h0, 32'h0,         4'd1},   // R1 absent slot
    {1'b1, 12'h0F0, 4'hF, 32'h1234_5678, 32'h0, 4'd2},
    {1'b0, 12'h0F0, 4'hF, 32'h0, 32'h1234_5678, 4'd2},   // R2, R3 no run
    {1'b0, 12'h0F2, 4'hF, 32'h0, 32'h0,         4'd1}    // R1 misaligned
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] s = 4'hF);
    @(negedge clk);
    busAddr = a; busWe = 1'b1; busStrb = s; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWe = 1'b0;
    #1 d = busRdata;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d, c0, c1;
    int pulses;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    chk("R1 irq after reset", 32'(irqOut), 32'h0);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][84]) wr(VEC[i][83:72], VEC[i][67:36], VEC[i][71:68]);
      else begin
        rd(VEC[i][83:72], d);
        chk($sformatf("R%0d table %0d", VEC[i][3:0], i), d, VEC[i][35:4]);
      end
    end

    // R2 counting and freezing, carry
    doReset();
    wr(12'h010, 32'h1);
    rd(12'h0F0, c0); waitCyc(4); rd(12'h0F0, c1);
    chk("R2 run step", c1 - c0, 32'd5);
    wr(12'h010, 32'h0);
    rd(12'h0F0, c0); waitCyc(4); rd(12'h0F0, c1);
    chk("R2 frozen", c1 - c0, 32'd0);
    wr(12'h0F0, 32'hFFFF_FFFE); wr(12'h0F4, 32'h0);
    wr(12'h010, 32'h1); waitCyc(10); wr(12'h010, 32'h0);
    rd(12'h0F4, d);
    chk("R2 carry into high half", d, 32'h1);

    // R4/R9: crossing a 32-bit boundary against three channels
    doReset();
    wr(12'h0F0, 32'hFFFF_FFF8); wr(12'h0F4, 32'h1);
    wr(12'h100, 32'h6);   wr(12'h108, 32'h8); wr(12'h10C, 32'h3);   // wrong high
    wr(12'h120, 32'h106); wr(12'h128, 32'h8); wr(12'h12C, 32'h5);   // 32-bit
    wr(12'h140, 32'h6);   wr(12'h148, 32'h8); wr(12'h14C, 32'h2);   // exact
    rd(12'h020, d);
    chk("R4 no match while frozen", d, 32'h0);
    wr(12'h010, 32'h1); waitCyc(40);
    rd(12'h020, d);
    chk("R4 R9 status pattern", d, 32'h6);
    chk("R5 level irq pattern", 32'(irqOut), 32'h6);
    rd(12'h12C, d);
    chk("R9 high word ignored", d, 32'h0);

    // R5 level hold and acknowledge
    doReset();
    wr(12'h0F0, 32'h10);
    wr(12'h100, 32'h6); wr(12'h108, 32'h20); wr(12'h10C, 32'h0);
    wr(12'h010, 32'h1); waitCyc(40);
    chk("R5 level irq high", 32'(irqOut[0]), 32'h1);
    waitCyc(10);
    chk("R5 level irq held", 32'(irqOut[0]), 32'h1);
    wr(12'h020, 32'h1);
    rd(12'h020, d);
    chk("R5 status cleared", d, 32'h0);
    chk("R5 irq dropped", 32'(irqOut[0]), 32'h0);

    // R6 edge pulse and ignored acknowledge
    doReset();
    wr(12'h0F0, 32'h10);
    wr(12'h100, 32'h4); wr(12'h108, 32'h20); wr(12'h10C, 32'h0);
    wr(12'h010, 32'h1);
    pulses = 0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (irqOut[0]) pulses++;
    end
    chk("R6 one pulse", 32'(pulses), 32'd1);
    wr(12'h020, 32'h1);
    rd(12'h020, d);
    chk("R6 status write ignored", d, 32'h1);
    chk("R6 irq low after pulse", 32'(irqOut[0]), 32'h0);

    // R7/R10 enable gating with routing and message bits set
    doReset();
    wr(12'h0F0, 32'h10);
    wr(12'h100, 32'h7E02); wr(12'h108, 32'h20); wr(12'h10C, 32'h0);
    wr(12'h010, 32'h1); waitCyc(40);
    rd(12'h020, d);
    chk("R7 status without enable", d, 32'h1);
    chk("R7 R10 irq gated", 32'(irqOut[0]), 32'h0);
    wr(12'h100, 32'h7E06); waitCyc(1);
    chk("R7 irq after enable", 32'(irqOut[0]), 32'h1);

    // R8 periodic channel
    doReset();
    wr(12'h140, 32'h4E); wr(12'h148, 32'h100); wr(12'h14C, 32'h0);
    rd(12'h140, d);
    chk("R8 value-set self-clears", d, 32'h0E);
    wr(12'h0F0, 32'hF0);
    wr(12'h010, 32'h1); waitCyc(40); wr(12'h010, 32'h0);
    rd(12'h148, d);
    chk("R8 first advance", d, 32'h200);
    rd(12'h020, d);
    chk("R8 first match status", d, 32'h4);
    wr(12'h020, 32'h4);
    rd(12'h020, d);
    chk("R8 status cleared", d, 32'h0);
    wr(12'h010, 32'h1); waitCyc(300); wr(12'h010, 32'h0);
    rd(12'h148, d);
    chk("R8 second advance", d, 32'h300);
    rd(12'h020, d);
    chk("R8 second match status", d, 32'h4);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule